// File: doc/BRIEF.md
# LIN Transmitter Fault Supervisor

This block is the digital guard that sits in front of a LIN transceiver's transmit driver. It watches the transmit data pin for a level stuck dominant past a timeout, and it takes flags from the analog sensing for over-current, over-temperature and a shorted receive-data pin. From these it keeps sticky status flags, decides whether the driver may be enabled, raises a maskable interrupt and forces the receive-only control bit on.

Each fault class has its own recovery rule. A dominant timeout is released as soon as transmit data returns high. Over-temperature is released once the fault is gone and transmit data is high. A receive-data short is released on a receive-data transition with transmit data high. Over-current is only recorded and never turns the driver off. A status read is a one-cycle strobe. It clears a flag only when that flag's condition is absent, and it clears the pending interrupt. Inputs are assumed to be synchronous to `clk`. The reset is synchronous and active-low.

Top module: `lin_tx_supervisor`

## Requirements
- R1: With `txd_i` low at `TXD_TO` consecutive rising edges, `status_o[0]` (stuck-dominant flag) is set and `tx_en_o` drops after the last of those edges. After only `TXD_TO-1` such edges the flag is still clear.
- R2: The stuck-dominant shutdown ends one edge after `txd_i` is sampled high. A status read clears `status_o[0]` only if `txd_i` is high at that edge. A read with `txd_i` low leaves the flag set.
- R3: An over-current flag input sets `status_o[1]`. It never causes a shutdown, so `tx_en_o` stays high while over-current persists once receive-only is cleared.
- R4: An over-temperature flag input sets `status_o[2]` and disables the driver. The driver is enabled again only after the fault is gone and `txd_i` is sampled high.
- R5: A receive-data short flag input sets `status_o[3]` and disables the driver. The driver is enabled again only after the short is gone, `rxd_i` changes level and `txd_i` is high at that same edge.
- R6: A status read clears `status_o[1]`, `status_o[2]` or `status_o[3]` only if that fault input is low at the read edge. Without a read, every flag holds.
- R7: A new fault event (a rising fault input or a stuck-dominant timeout) sets `irq_o` at that edge when `irq_en_i` is high. `irq_o` then holds until a status read. A masked event still sets its flag but leaves `irq_o` low.
- R8: Any new fault event sets `rx_only_o`, and this wins over a write of 0 in the same cycle. Otherwise `rxo_wr_i` loads `rxo_wdata_i`. While `rx_only_o` is high, `tx_en_o` is low.
- R9: A fault event and a status read in the same cycle leave both the flag and `irq_o` set.
- R10: After reset, `status_o` is 0, `irq_o` and `rx_only_o` are 0, and `tx_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Transmit data pin level (0 = dominant) |
| rxd_i | input | 1 | Receive data pin level |
| oc_flt_i | input | 1 | Over-current flag from analog sensing |
| ot_flt_i | input | 1 | Over-temperature flag from analog sensing |
| rxs_flt_i | input | 1 | Receive-data short flag from analog sensing |
| stat_rd_i | input | 1 | One-cycle status read strobe |
| irq_en_i | input | 1 | Interrupt enable for fault events |
| rxo_wr_i | input | 1 | Write strobe for the receive-only bit |
| rxo_wdata_i | input | 1 | Value written to the receive-only bit |
| tx_en_o | output | 1 | Transmit driver enable |
| status_o | output | 4 | Flags: [0] stuck dominant, [1] over-current, [2] over-temperature, [3] receive-data short |
| irq_o | output | 1 | Interrupt request |
| rx_only_o | output | 1 | Receive-only bit |

## Verification
The collision that matters is a status read landing in the same cycle as a new fault event. The read wants to clear the flag and the interrupt, while the event wants to set them. The bench provokes this on purpose by raising the over-current input in the read cycle, together with a receive-only write of 0. It expects the flag, `irq_o` and `rx_only_o` all to remain set. Randomized traffic with frequent reads and fault edges then produces the same overlap many more times, and each cycle is judged against a bench model built from the requirements.

// File: rtl/lin_sup_pkg.sv
// Package: status bit positions shared by the supervisor modules and the bench.
package lin_sup_pkg;
    localparam int ST_W     = 4;
    localparam int ST_TXDOM = 0;
    localparam int ST_OC    = 1;
    localparam int ST_OT    = 2;
    localparam int ST_RXS   = 3;
    localparam int LVL_N    = 3;  // level-sensed fault classes (OC, OT, RXS)
endpackage

// File: rtl/lin_txd_watch.sv
// Module: lin_txd_watch
// Counts consecutive clock edges with TXD dominant and emits a one-cycle hit
// on the edge where the count reaches TXD_TO. The count saturates, so a held
// dominant level yields a single hit. Assumes txd_i is already synchronous.
module lin_txd_watch #(
    parameter int TXD_TO = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    output logic hit_o
);
    localparam int CW = $clog2(TXD_TO + 1);

    logic [CW-1:0] cnt;

    // Hit on the edge that would make the dominant run TXD_TO long.
    assign hit_o = !txd_i && (cnt == CW'(TXD_TO - 1));

    // Dominant-run counter: restarts on recessive, holds at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (txd_i)
            cnt <= '0;
        else if (cnt != CW'(TXD_TO))
            cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TXD_TO));
    p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/lin_fault_track.sv
// Module: lin_fault_track
// Holds the sticky status flags and the per-class shutdown states. It reports
// a combined fault event for interrupt and receive-only handling. Level faults
// raise an event on their rising edge only. Flags clear on a read when their
// condition is absent, and an event in the read cycle wins over the clear.
module lin_fault_track
    import lin_sup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txd_i,
    input  logic             rxd_i,
    input  logic [LVL_N-1:0] lvl_i,     // [0] OC, [1] OT, [2] RXS
    input  logic             stat_rd_i,
    input  logic             dom_hit_i,
    output logic [ST_W-1:0]  flags_o,
    output logic             shut_o,
    output logic             evt_o
);
    logic [LVL_N-1:0] lvl_q;
    logic             sd_dom, sd_ot, sd_rxs;
    logic             rxd_q;
    logic             rxd_edge;

    assign rxd_edge = rxd_i ^ rxd_q;
    assign evt_o    = dom_hit_i | (|(lvl_i & ~lvl_q));
    assign shut_o   = sd_dom | sd_ot | sd_rxs;

    // Previous samples for edge detection of fault levels and RXD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            rxd_q <= 1'b1;
        end else begin
            lvl_q <= lvl_i;
            rxd_q <= rxd_i;
        end
    end

    // Stuck-dominant flag: cleared by a read only while TXD is recessive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_o[ST_TXDOM] <= 1'b0;
        else if (dom_hit_i)
            flags_o[ST_TXDOM] <= 1'b1;
        else if (stat_rd_i && txd_i)
            flags_o[ST_TXDOM] <= 1'b0;
    end

    // Level-sensed flags: set while the fault is present, read-clear otherwise.
    for (genvar k = 0; k < LVL_N; k++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[k+1] <= 1'b0;
            else if (lvl_i[k])
                flags_o[k+1] <= 1'b1;
            else if (stat_rd_i)
                flags_o[k+1] <= 1'b0;
        end

        p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            flags_o[k+1] && !stat_rd_i |=> flags_o[k+1]);
    end

    // Shutdown states, each with its own release rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_dom <= 1'b0;
            sd_ot  <= 1'b0;
            sd_rxs <= 1'b0;
        end else begin
            sd_dom <= dom_hit_i | (sd_dom & ~txd_i);
            sd_ot  <= lvl_i[1]  | (sd_ot  & ~txd_i);
            sd_rxs <= lvl_i[2]  | (sd_rxs & ~(rxd_edge & txd_i));
        end
    end

    p_dom_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dom && txd_i |=> !sd_dom);
    p_ot_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i[1] |=> sd_ot && flags_o[ST_OT]);
    p_rxs_shut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i[2] |=> sd_rxs && flags_o[ST_RXS]);
endmodule

// File: rtl/lin_irq_rxo.sv
// Module: lin_irq_rxo
// Interrupt request and receive-only bit. A fault event sets the request when
// enabled and always forces receive-only on. A read clears the request. The
// receive-only bit otherwise follows software writes.
module lin_irq_rxo (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic stat_rd_i,
    input  logic irq_en_i,
    input  logic rxo_wr_i,
    input  logic rxo_wdata_i,
    output logic irq_o,
    output logic rx_only_o
);
    // Interrupt: set by an enabled event, held until a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (evt_i && irq_en_i)
            irq_o <= 1'b1;
        else if (stat_rd_i)
            irq_o <= 1'b0;
    end

    // Receive-only: a fault event wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_only_o <= 1'b0;
        else if (evt_i)
            rx_only_o <= 1'b1;
        else if (rxo_wr_i)
            rx_only_o <= rxo_wdata_i;
    end

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !stat_rd_i |=> irq_o);
    p_rxo_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> rx_only_o);
    p_irq_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && irq_en_i && stat_rd_i |=> irq_o);
endmodule

// File: rtl/lin_tx_supervisor.sv
// Module: lin_tx_supervisor (top)
// Joins the dominant-timeout watcher, the fault tracker and the interrupt /
// receive-only control. The driver is enabled only when no shutdown is active
// and receive-only is clear. All inputs are assumed synchronous to clk.
module lin_tx_supervisor
    import lin_sup_pkg::*;
#(
    parameter int TXD_TO = 50_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txd_i,
    input  logic            rxd_i,
    input  logic            oc_flt_i,
    input  logic            ot_flt_i,
    input  logic            rxs_flt_i,
    input  logic            stat_rd_i,
    input  logic            irq_en_i,
    input  logic            rxo_wr_i,
    input  logic            rxo_wdata_i,
    output logic            tx_en_o,
    output logic [ST_W-1:0] status_o,
    output logic            irq_o,
    output logic            rx_only_o
);
    logic dom_hit, shut, evt;

    lin_txd_watch #(.TXD_TO(TXD_TO)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .txd_i (txd_i),
        .hit_o (dom_hit)
    );

    lin_fault_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .txd_i     (txd_i),
        .rxd_i     (rxd_i),
        .lvl_i     ({rxs_flt_i, ot_flt_i, oc_flt_i}),
        .stat_rd_i (stat_rd_i),
        .dom_hit_i (dom_hit),
        .flags_o   (status_o),
        .shut_o    (shut),
        .evt_o     (evt)
    );

    lin_irq_rxo u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .stat_rd_i   (stat_rd_i),
        .irq_en_i    (irq_en_i),
        .rxo_wr_i    (rxo_wr_i),
        .rxo_wdata_i (rxo_wdata_i),
        .irq_o       (irq_o),
        .rx_only_o   (rx_only_o)
    );

    // Driver enable: no active shutdown and not receive-only.
    assign tx_en_o = !shut && !rx_only_o;

    p_rxo_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_only_o) |-> !tx_en_o);
    p_oc_no_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flt_i && !ot_flt_i && !rxs_flt_i && !dom_hit && !shut && !rx_only_o
        && !evt && !(rxo_wr_i && rxo_wdata_i) |=> tx_en_o);
endmodule

// File: tb/test_lin_tx_supervisor.sv
module test_lin_tx_supervisor;
    localparam int TO = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic txd = 1'b1, rxd = 1'b1, oc = 1'b0, ot = 1'b0, rxs = 1'b0;
    logic rd = 1'b0, ien = 1'b0, wr = 1'b0, wd = 1'b0;
    logic tx_en, irq, rxo;
    logic [3:0] st;

    int errors = 0, checks = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    lin_tx_supervisor #(.TXD_TO(TO)) i_lin_tx_supervisor (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .rxd_i(rxd),
        .oc_flt_i(oc), .ot_flt_i(ot), .rxs_flt_i(rxs), .stat_rd_i(rd),
        .irq_en_i(ien), .rxo_wr_i(wr), .rxo_wdata_i(wd),
        .tx_en_o(tx_en), .status_o(st), .irq_o(irq), .rx_only_o(rxo)
    );

    // Reference model built from the requirements, updated at each rising edge.
    int m_cnt;
    logic [3:0] m_st;
    logic m_sd_dom, m_sd_ot, m_sd_rxs, m_irq, m_rxo;
    logic m_oc_q, m_ot_q, m_rxs_q, m_rxd_q;

    function automatic logic exp_tx_en();
        return !(m_sd_dom || m_sd_ot || m_sd_rxs || m_rxo);
    endfunction

    always @(posedge clk) begin
        logic hit, evt;
        if (!rst_n) begin
            m_cnt <= 0; m_st <= '0; m_sd_dom <= 0; m_sd_ot <= 0; m_sd_rxs <= 0;
            m_irq <= 0; m_rxo <= 0; m_oc_q <= 0; m_ot_q <= 0; m_rxs_q <= 0;
            m_rxd_q <= 1;
        end else begin
            hit = !txd && (m_cnt == TO - 1);                           // R1
            evt = hit || (oc && !m_oc_q) || (ot && !m_ot_q) || (rxs && !m_rxs_q);
            m_cnt <= txd ? 0 : ((m_cnt == TO) ? TO : m_cnt + 1);
            m_st[0] <= hit || (m_st[0] && !(rd && txd));              // R2
            m_st[1] <= oc  || (m_st[1] && !rd);                       // R3 R6
            m_st[2] <= ot  || (m_st[2] && !rd);                       // R4 R6
            m_st[3] <= rxs || (m_st[3] && !rd);                       // R5 R6
            m_sd_dom <= hit || (m_sd_dom && !txd);
            m_sd_ot  <= ot  || (m_sd_ot && !txd);
            m_sd_rxs <= rxs || (m_sd_rxs && !((rxd != m_rxd_q) && txd));
            m_irq <= (evt && ien) || (m_irq && !rd);                  // R7 R9
            m_rxo <= evt ? 1'b1 : (wr ? wd : m_rxo);                  // R8
            m_oc_q <= oc; m_ot_q <= ot; m_rxs_q <= rxs; m_rxd_q <= rxd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R1 stuck-dominant flag", st[0], m_st[0]);
            chk("R6 fault flags", st[3:1], m_st[3:1]);
            chk("R7 irq", irq, m_irq);
            chk("R8 rx_only", rxo, m_rxo);
            chk("R2 tx_en", tx_en, exp_tx_en());
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1; tick(); rd = 0;
    endtask

    task automatic clr_rxo();
        wr = 1; wd = 0; tick(); wr = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        rst_n = 1;
        tick();
        chk("R10 tx_en after reset", tx_en, 1);
        chk("R10 status after reset", st, 0);
        chk("R10 irq after reset", irq, 0);
        chk("R10 rx_only after reset", rxo, 0);
        cmp_on = 1;

        // R1 / R2: stuck-dominant timeout and release
        ien = 1; txd = 0;
        tick(TO - 1);
        chk("R1 flag clear at TO-1", st[0], 0);
        tick();
        chk("R1 flag set at TO", st[0], 1);
        chk("R1 tx_en off", tx_en, 0);
        chk("R7 irq on timeout", irq, 1);
        chk("R8 rx_only forced", rxo, 1);
        do_read();
        chk("R2 read with txd low keeps flag", st[0], 1);
        chk("R7 read clears irq", irq, 0);
        txd = 1; wr = 1; wd = 0; tick(); wr = 0;
        chk("R2 tx_en back after txd high", tx_en, 1);
        do_read();
        chk("R2 read with txd high clears flag", st[0], 0);

        // R3 / R6: over-current records only
        oc = 1; tick(2);
        chk("R3 oc flag", st[1], 1);
        clr_rxo();
        chk("R3 no shutdown on oc", tx_en, 1);
        do_read();
        chk("R6 read with oc present keeps flag", st[1], 1);
        oc = 0; do_read();
        chk("R6 read with oc gone clears flag", st[1], 0);

        // R4: over-temperature shutdown and release
        ot = 1; tick(2); clr_rxo();
        chk("R4 ot flag", st[2], 1);
        chk("R4 tx off during ot", tx_en, 0);
        ot = 0; txd = 0; tick(3);
        chk("R4 stays off with txd low", tx_en, 0);
        txd = 1; tick();
        chk("R4 released with txd high", tx_en, 1);
        do_read();

        // R5: RXD short shutdown and release on RXD transition
        rxs = 1; tick(2); rxs = 0; clr_rxo(); tick(2);
        chk("R5 rxs flag", st[3], 1);
        chk("R5 off without rxd edge", tx_en, 0);
        rxd = 0; tick();
        chk("R5 released on rxd edge", tx_en, 1);
        rxd = 1; do_read();

        // R7: masked event sets flag but not irq
        ien = 0; oc = 1; tick(); oc = 0; tick();
        chk("R7 masked flag", st[1], 1);
        chk("R7 masked irq", irq, 0);
        do_read(); clr_rxo();

        // R9 / R8: event, read and rx_only write 0 in one cycle
        ien = 1; oc = 1; rd = 1; wr = 1; wd = 0; tick();
        rd = 0; wr = 0; oc = 0;
        chk("R9 flag survives same-cycle read", st[1], 1);
        chk("R9 irq survives same-cycle read", irq, 1);
        chk("R8 event beats write", rxo, 1);
        do_read(); clr_rxo();

        // Random traffic against the model
        for (int i = 0; i < 5000; i++) begin
            if ($urandom % 40 == 0) txd = ~txd;
            if ($urandom % 4 == 0) rxd = ~rxd;
            if ($urandom % 30 == 0) oc = ~oc;
            if ($urandom % 30 == 0) ot = ~ot;
            if ($urandom % 30 == 0) rxs = ~rxs;
            if ($urandom % 50 == 0) ien = ~ien;
            rd = ($urandom % 8 == 0);
            wr = ($urandom % 10 == 0);
            wd = $urandom % 2;
            tick();
        end
        rd = 0; wr = 0;
        tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule